// File: doc/BRIEF.md
# PAL Raster Timing Generator

This block produces the horizontal and vertical timing for a 625-line interlaced PAL composite test signal. It runs from a sample clock at four times the colour subcarrier (17.734475 MHz). A sample counter walks along each line and a line counter walks through the frame. Every timing edge is decoded from those two counts: sync, blanking, the colour burst gate and the active-picture gate.

For the pattern and chroma logic downstream, the block also gives the horizontal position inside the active picture, the current line number, the field flag and a PAL phase-alternation flag that flips on every line. A normal line is 1135 clocks long. The subcarrier does not divide evenly into a line, so the last line of each field is two clocks longer. This keeps the subcarrier phase locked to the raster over a full frame. Vertical sync uses broad pulses only; there is no equalising-pulse pattern.

All outputs are plain level signals decoded from registered counters. The block has no handshake, and nothing downstream can hold it back.

Top module: `pal_raster_gen`

## Requirements
- R1: While `rst_n` is low, the sample count and line number are 0, `field_o` is 0 and `pal_sw_o` is 0.
- R2: A normal line lasts `LINE_CLKS` clocks (default 1135). The sample count runs from 0 to `LINE_CLKS-1`, and the line number advances when it wraps.
- R3: The last line of each field lasts `LINE_CLKS+EXTRA_CLKS` clocks (default 1137). These lines are line `LINES/2-1` (311) and line `LINES-1` (624).
- R4: The line number wraps from `LINES-1` to 0. `field_o` is 0 on lines below `LINES/2` and 1 on all other lines.
- R5: `pal_sw_o` inverts each time a new line starts, and holds steady within a line.
- R6: Outside the vertical sync lines, `sync_o` is high for sample counts 0 to `HSYNC_CLKS-1` (default 83, about 4.7 µs).
- R7: On the first `VSYNC_LINES` lines of each field (default 3), `sync_o` is a broad pulse. It is high for sample counts below `LINE_CLKS-HSYNC_CLKS`.
- R8: `blank_o` is high in three cases:
  - for the first `HBLANK_HEAD` counts of a line (default 213);
  - for the last `HBLANK_TAIL` counts of that line's own length (default 27);
  - on the whole of the first `VBLANK_LINES` lines of each field (default 25).
- R9: `burst_o` is high for `BURST_LEN` clocks (default 40), starting at sample count `BURST_START` (default 99). It is never high on vertical-blanking lines.
- R10: `active_o` is the inverse of `blank_o`. `hpos_o` equals the sample count minus `HBLANK_HEAD` while `active_o` is high, and is 0 otherwise.
- R11: `line_o` shows the current line number, 0 to `LINES-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the subcarrier |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_o | output | 1 | Composite sync, high = sync tip |
| blank_o | output | 1 | Blanking interval |
| burst_o | output | 1 | Colour burst gate |
| active_o | output | 1 | Active picture gate |
| hpos_o | output | PIX_W | Position within the active picture |
| line_o | output | LINE_W | Line number within the frame |
| field_o | output | 1 | Field flag, 0 = first field |
| pal_sw_o | output | 1 | Per-line phase-alternation flag |

## Verification
The bench runs a reduced raster over three frames and targets the two stretched lines. A design that stretched the wrong line, or stretched no line, would move every later edge and be caught at once. It would also be caught if it placed the trailing blanking edge by the normal line length instead of the stretched one. The bench also checks the frame wrap and the field flag at the odd split between the two fields; an off-by-one there moves the broad-pulse and vertical-blanking lines of the second field. Burst suppression and the phase-alternation flag are compared on every cycle. A gate left open on a blanking line, or a flag that flips only at the frame boundary, shows up as a mismatch.

// File: rtl/pal_timing_pkg.sv
package pal_timing_pkg;
  typedef struct packed {
    logic sync;
    logic blank;
    logic burst;
    logic active;
  } gate_t;
endpackage

// File: rtl/pal_pix_counter.sv
module pal_pix_counter #(
  parameter int LINE_CLKS  = 1135,
  parameter int EXTRA_CLKS = 2,
  parameter int PIX_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_line,
  output logic [PIX_W-1:0] pix,
  output logic             eol
);
  localparam logic [PIX_W-1:0] LAST_NORM = PIX_W'(LINE_CLKS - 1);
  localparam logic [PIX_W-1:0] LAST_LONG = PIX_W'(LINE_CLKS + EXTRA_CLKS - 1);

  assign eol = (pix == (long_line ? LAST_LONG : LAST_NORM));

  always_ff @(posedge clk) begin
    if (!rst_n)   pix <= '0;
    else if (eol) pix <= '0;
    else          pix <= pix + 1'b1;
  end
endmodule

// File: rtl/pal_line_counter.sv
module pal_line_counter #(
  parameter int LINES    = 625,
  parameter int F0_LINES = 312,
  parameter int LINE_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eol,
  output logic [LINE_W-1:0] line,
  output logic [LINE_W-1:0] fline,
  output logic              field,
  output logic              long_line,
  output logic              pal_sw
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] F0_N      = LINE_W'(F0_LINES);
  localparam logic [LINE_W-1:0] F0_LAST   = LINE_W'(F0_LINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line   <= '0;
      pal_sw <= 1'b0;
    end else if (eol) begin
      line   <= (line == LAST_LINE) ? '0 : line + 1'b1;
      pal_sw <= ~pal_sw;
    end
  end

  assign field     = (line >= F0_N);
  assign fline     = field ? (line - F0_N) : line;
  assign long_line = (line == F0_LAST) || (line == LAST_LINE);
endmodule

// File: rtl/pal_gate_decode.sv
module pal_gate_decode
  import pal_timing_pkg::*;
#(
  parameter int LINE_CLKS    = 1135,
  parameter int EXTRA_CLKS   = 2,
  parameter int HSYNC_CLKS   = 83,
  parameter int HBLANK_HEAD  = 213,
  parameter int HBLANK_TAIL  = 27,
  parameter int BURST_START  = 99,
  parameter int BURST_LEN    = 40,
  parameter int VSYNC_LINES  = 3,
  parameter int VBLANK_LINES = 25,
  parameter int PIX_W        = 11,
  parameter int LINE_W       = 10
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] fline,
  input  logic              long_line,
  output gate_t             gates,
  output logic [PIX_W-1:0]  hpos
);
  localparam logic [PIX_W-1:0] HS_END    = PIX_W'(HSYNC_CLKS);
  localparam logic [PIX_W-1:0] BROAD_END = PIX_W'(LINE_CLKS - HSYNC_CLKS);
  localparam logic [PIX_W-1:0] HEAD_END  = PIX_W'(HBLANK_HEAD);
  localparam logic [PIX_W-1:0] TAIL_NORM = PIX_W'(LINE_CLKS - HBLANK_TAIL);
  localparam logic [PIX_W-1:0] TAIL_LONG = PIX_W'(LINE_CLKS + EXTRA_CLKS - HBLANK_TAIL);
  localparam logic [PIX_W-1:0] BS_BEG    = PIX_W'(BURST_START);
  localparam logic [PIX_W-1:0] BS_END    = PIX_W'(BURST_START + BURST_LEN);
  localparam logic [LINE_W-1:0] VS_N     = LINE_W'(VSYNC_LINES);
  localparam logic [LINE_W-1:0] VB_N     = LINE_W'(VBLANK_LINES);

  logic vsync_line, vblank_line, hblank;

  always_comb begin
    vsync_line   = (fline < VS_N);
    vblank_line  = (fline < VB_N);
    hblank       = (pix < HEAD_END) || (pix >= (long_line ? TAIL_LONG : TAIL_NORM));
    gates.sync   = vsync_line ? (pix < BROAD_END) : (pix < HS_END);
    gates.blank  = hblank || vblank_line;
    gates.burst  = !vblank_line && (pix >= BS_BEG) && (pix < BS_END);
    gates.active = !gates.blank;
    hpos         = gates.active ? (pix - HEAD_END) : '0;
  end
endmodule

// File: rtl/pal_raster_gen.sv
module pal_raster_gen
  import pal_timing_pkg::*;
#(
  parameter int LINE_CLKS    = 1135,
  parameter int EXTRA_CLKS   = 2,
  parameter int LINES        = 625,
  parameter int HSYNC_CLKS   = 83,
  parameter int HBLANK_HEAD  = 213,
  parameter int HBLANK_TAIL  = 27,
  parameter int BURST_START  = 99,
  parameter int BURST_LEN    = 40,
  parameter int VSYNC_LINES  = 3,
  parameter int VBLANK_LINES = 25,
  parameter int PIX_W        = $clog2(LINE_CLKS + EXTRA_CLKS),
  parameter int LINE_W       = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sync_o,
  output logic              blank_o,
  output logic              burst_o,
  output logic              active_o,
  output logic [PIX_W-1:0]  hpos_o,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              pal_sw_o
);
  localparam int F0_LINES = LINES / 2;

  logic [PIX_W-1:0]  pix;
  logic              eol;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] fline;
  logic              long_line;
  gate_t             gates;

  pal_pix_counter #(
    .LINE_CLKS(LINE_CLKS), .EXTRA_CLKS(EXTRA_CLKS), .PIX_W(PIX_W)
  ) u_pix (
    .clk(clk), .rst_n(rst_n), .long_line(long_line), .pix(pix), .eol(eol)
  );

  pal_line_counter #(
    .LINES(LINES), .F0_LINES(F0_LINES), .LINE_W(LINE_W)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .eol(eol), .line(line_q), .fline(fline),
    .field(field_o), .long_line(long_line), .pal_sw(pal_sw_o)
  );

  pal_gate_decode #(
    .LINE_CLKS(LINE_CLKS), .EXTRA_CLKS(EXTRA_CLKS), .HSYNC_CLKS(HSYNC_CLKS),
    .HBLANK_HEAD(HBLANK_HEAD), .HBLANK_TAIL(HBLANK_TAIL),
    .BURST_START(BURST_START), .BURST_LEN(BURST_LEN),
    .VSYNC_LINES(VSYNC_LINES), .VBLANK_LINES(VBLANK_LINES),
    .PIX_W(PIX_W), .LINE_W(LINE_W)
  ) u_dec (
    .pix(pix), .fline(fline), .long_line(long_line), .gates(gates), .hpos(hpos_o)
  );

  assign sync_o   = gates.sync;
  assign blank_o  = gates.blank;
  assign burst_o  = gates.burst;
  assign active_o = gates.active;
  assign line_o   = line_q;
endmodule

// File: rtl/pal_raster_chk.sv
module pal_raster_chk #(
  parameter int LINE_CLKS = 1135,
  parameter int LINES     = 625,
  parameter int PIX_W     = 11,
  parameter int LINE_W    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PIX_W-1:0]  pix,
  input logic              eol,
  input logic [LINE_W-1:0] line,
  input logic              pal_sw,
  input logic              sync,
  input logic              blank,
  input logic              burst,
  input logic              active
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] F0_LAST   = LINE_W'(LINES / 2 - 1);
  localparam logic [PIX_W-1:0]  NORM_LAST = PIX_W'(LINE_CLKS - 1);
  localparam logic [PIX_W-1:0]  NORM_LEN  = PIX_W'(LINE_CLKS);

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !eol |=> (pix == $past(pix) + 1'b1) && (line == $past(line))); // R2
  AST_LONG_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ((line == F0_LAST || line == LAST_LINE) && pix == NORM_LAST) |=> (pix == NORM_LEN)); // R3
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && line != LAST_LINE) |=> (line == $past(line) + 1'b1) && (pix == '0)); // R4
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && line == LAST_LINE) |=> (line == '0)); // R4
  AST_PALSW_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> (pal_sw != $past(pal_sw))); // R5
  AST_PALSW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eol |=> $stable(pal_sw)); // R5
  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> blank); // R6
  AST_BURST_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> (blank && !active)); // R9
endmodule

bind pal_raster_gen pal_raster_chk #(
  .LINE_CLKS(LINE_CLKS), .LINES(LINES), .PIX_W(PIX_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix(pix), .eol(eol), .line(line_q),
  .pal_sw(pal_sw_o), .sync(sync_o), .blank(blank_o), .burst(burst_o),
  .active(active_o)
);

// File: tb/pal_raster_gen_tb.sv
module pal_raster_gen_tb;
  localparam int LC = 60, EX = 2, NL = 13, HS = 5, HH = 14, HT = 3;
  localparam int BS = 7, BL = 4, VS = 1, VB = 2, F0 = NL / 2;
  localparam int PW = $clog2(LC + EX), LW = $clog2(NL);
  localparam int FRAME = NL * LC + 2 * EX;
  localparam int STEPS = 3 * FRAME;

  typedef struct {
    int sync, blank, burst, active, hpos, line, field, pal;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_o, blank_o, burst_o, active_o, field_o, pal_sw_o;
  logic [PW-1:0] hpos_o;
  logic [LW-1:0] line_o;
  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  pal_raster_gen #(
    .LINE_CLKS(LC), .EXTRA_CLKS(EX), .LINES(NL), .HSYNC_CLKS(HS),
    .HBLANK_HEAD(HH), .HBLANK_TAIL(HT), .BURST_START(BS), .BURST_LEN(BL),
    .VSYNC_LINES(VS), .VBLANK_LINES(VB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_o(sync_o), .blank_o(blank_o),
    .burst_o(burst_o), .active_o(active_o), .hpos_o(hpos_o), .line_o(line_o),
    .field_o(field_o), .pal_sw_o(pal_sw_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: expected raster for every cycle, built from the requirements
  task automatic drive_expected();
    int p = 0, l = 0, pal = 0;
    for (int s = 0; s <= STEPS; s++) begin
      exp_t e;
      int len, fl, fld;
      len = (l == F0 - 1 || l == NL - 1) ? LC + EX : LC;   // R3
      fld = (l >= F0) ? 1 : 0;                             // R4
      fl  = fld ? l - F0 : l;
      e.sync  = (fl < VS) ? int'(p < LC - HS) : int'(p < HS);
      e.blank = int'(p < HH || p >= len - HT || fl < VB);
      e.burst = int'(fl >= VB && p >= BS && p < BS + BL);
      e.active = 1 - e.blank;
      e.hpos  = e.active ? p - HH : 0;
      e.line  = l; e.field = fld; e.pal = pal;
      q.push_back(e);
      if (p == len - 1) begin
        p = 0; pal = 1 - pal;
        l = (l == NL - 1) ? 0 : l + 1;
      end else p++;
    end
  endtask

  task automatic compare(input exp_t e);
    chk("R6/R7", "sync", int'(sync_o), e.sync);
    chk("R8", "blank", int'(blank_o), e.blank);
    chk("R9", "burst", int'(burst_o), e.burst);
    chk("R10", "active", int'(active_o), e.active);
    chk("R10", "hpos", int'(hpos_o), e.hpos);
    chk("R11", "line", int'(line_o), e.line);
    chk("R4", "field", int'(field_o), e.field);
    chk("R5", "pal_sw", int'(pal_sw_o), e.pal);
  endtask

  // Monitor
  initial begin
    exp_t e;
    drive_expected();
    repeat (3) @(posedge clk);
    @(negedge clk);
    e = q.pop_front();
    chk("R1", "reset line", int'(line_o), 0);
    chk("R1", "reset field", int'(field_o), 0);
    chk("R1", "reset pal_sw", int'(pal_sw_o), 0);
    chk("R1", "reset hpos", int'(hpos_o), 0);
    compare(e);
    rst_n = 1'b1;
    for (int s = 1; s <= STEPS; s++) begin
      @(negedge clk);
      e = q.pop_front();
      compare(e);   // R2, R3 covered by line and edge positions
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule